// File: doc/BRIEF.md
# JTAG Page-Programming Data Register

This block is the set of data registers and the small sequencer behind page-oriented flash programming through a test access port. It runs entirely on the test clock and reacts to the capture, shift and update strobes that an external TAP controller produces. An external instruction decoder presents a 3-bit instruction code that says which register sits between TDI and TDO.

Four registers are provided. A one-bit register holds the processor core in reset. A 16-bit unlock register switches programming mode on or off, and only a fixed key opens it. A 16-bit command register sets the word address. An 8-bit byte register either collects bytes for writing into a flash page buffer or captures bytes read back from the array.

A word is moved as a low byte followed by a high byte. The word address advances only after a high byte and passes straight from one page into the next. During page load a spacing monitor makes sure that consecutive load updates are far enough apart for the byte sequencer to finish. An update that comes too early is dropped and is remembered in a sticky flag.

Top module: `jtag_flash_dr`

## Requirements
- R1: After `trst_n` is low, `prog_mode`, `core_reset`, `mem_wr_strobe`, `spacing_err`, `mem_hi_sel` and `mem_addr` are all 0.
- R2: With instruction code 1 a one-bit register sits in the scan path. Its capture loads the present `core_reset`, and its update copies the shifted bit into `core_reset`. This happens whether or not programming mode is on.
- R3: With instruction code 2, 16 bits are shifted in LSB first. An update with value 0xA370 sets `prog_mode` only while `core_reset` is 1. Any other nonzero value, or the key while `core_reset` is 0, leaves `prog_mode` unchanged.
- R4: An update of 0x0000 under instruction code 2 clears `prog_mode`. It does not change `core_reset`.
- R5: With instruction code 3, 16 bits are shifted in LSB first. If bit 15 is 1, an update loads the word address from bits 14:0 and selects the low byte (`mem_hi_sel`=0). If bit 15 is 0, the update changes nothing.
- R6: With instruction code 5, each Capture-DR loads `mem_rdata` for the current (`mem_addr`, `mem_hi_sel`) and shifts it out on TDO LSB first. The byte select then toggles. The address stays put after a low byte and increments after a high byte, so the first byte read comes from the commanded address.
- R7: Reading the high byte of the last word in a page moves `mem_addr` to the first word of the next page (page size `PAGE_WORDS`, default 64), with no wrap to the start of the same page.
- R8: With instruction code 4, an accepted update drives the 8 shifted bits onto `mem_wdata` and pulses `mem_wr_strobe` for one cycle, in the cycle after the update. During that pulse `mem_addr` and `mem_hi_sel` name the byte. Afterwards the select toggles, and the address increments after a high byte.
- R9: A load update that arrives fewer than `MIN_GAP` (default 11) cycles after the previous load update produces no strobe and no toggle or address change. It sets `spacing_err`, which stays 1 until reset.
- R10: While `prog_mode` is 0, updates and captures under codes 3, 4 and 5 have no effect, and TDO is 0 under those codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 3 | Active instruction: 0 none, 1 reset reg, 2 unlock, 3 command, 4 page load, 5 page read |
| capture_dr | input | 1 | TAP is in Capture-DR this cycle |
| shift_dr | input | 1 | TAP is in Shift-DR this cycle |
| update_dr | input | 1 | TAP is in Update-DR this cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the selected register) |
| core_reset | output | 1 | Holds the processor core in reset |
| prog_mode | output | 1 | Programming mode is unlocked |
| mem_addr | output | ADDR_W | Flash word address |
| mem_hi_sel | output | 1 | 0 low byte, 1 high byte of the word |
| mem_wdata | output | 8 | Byte to write |
| mem_wr_strobe | output | 1 | One-cycle byte write pulse |
| mem_rdata | input | 8 | Byte read at (`mem_addr`, `mem_hi_sel`), valid one cycle after they change |
| spacing_err | output | 1 | Sticky: a load update came too early |

## Verification
The read path is tried with a six-byte burst that starts two words before a page boundary. This tells apart low/high sequencing, post-increment after the high byte only, and the roll into the next page. Page load is run with updates exactly at the minimum spacing and one cycle short of it, which separates an accepted byte from a dropped one and shows that a dropped byte leaves the select and address alone. The unlock register is tried with the key while the core is not in reset, with a wrong key, with the correct key, and with zero. Command, load and read scans made while locked confirm through `mem_addr`, the write strobe and TDO that nothing moved.

// File: rtl/jfp_pkg.sv
package jfp_pkg;

  typedef enum logic [2:0] {
    INS_NONE    = 3'd0,
    INS_RESET   = 3'd1,
    INS_UNLOCK  = 3'd2,
    INS_COMMAND = 3'd3,
    INS_LOAD    = 3'd4,
    INS_READ    = 3'd5
  } jfp_instr_e;

  localparam logic [15:0] UNLOCK_KEY = 16'hA370;

  // Word address after one byte: advances only when the high byte was used.
  function automatic logic [14:0] next_word(input logic [14:0] addr, input logic hi);
    return hi ? addr + 15'd1 : addr;
  endfunction

  // Key acceptance: correct pattern and core already held in reset.
  function automatic logic key_accept(input logic [15:0] val, input logic in_reset);
    return (val == UNLOCK_KEY) && in_reset;
  endfunction

endpackage

// File: rtl/jfp_shift_reg.sv
module jfp_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] cap_val,
  input  logic         sh_en,
  input  logic         din,
  output logic [W-1:0] q
);

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (cap_en) q <= cap_val;
        else if (sh_en)  q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (cap_en) q <= cap_val;
        else if (sh_en)  q <= {din, q[W-1:1]};
      end
    end
  endgenerate

endmodule

// File: rtl/jfp_word_ctr.sv
module jfp_word_ctr #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              hi
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      hi   <= 1'b0;
    end else if (load) begin
      addr <= load_val;
      hi   <= 1'b0;
    end else if (step) begin
      addr <= ADDR_W'(jfp_pkg::next_word(15'(addr), hi));
      hi   <= ~hi;
    end
  end

endmodule

// File: rtl/jfp_gap_mon.sv
module jfp_gap_mon #(
  parameter int MIN_GAP = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic ok
);

  localparam int CW = $clog2(MIN_GAP + 1);

  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since <= CW'(MIN_GAP);
    else if (evt)                   since <= CW'(1);
    else if (since < CW'(MIN_GAP))  since <= since + 1'b1;
  end

  assign ok = (since >= CW'(MIN_GAP));

endmodule

// File: rtl/jtag_flash_dr.sv
module jtag_flash_dr #(
  parameter int PAGE_WORDS = 64,
  parameter int ADDR_W     = 15,
  parameter int MIN_GAP    = 11
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic [2:0]        instr,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic              core_reset,
  output logic              prog_mode,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_hi_sel,
  output logic [7:0]        mem_wdata,
  output logic              mem_wr_strobe,
  input  logic [7:0]        mem_rdata,
  output logic              spacing_err
);
  import jfp_pkg::*;

  localparam int PAGE_BITS = $clog2(PAGE_WORDS);

  jfp_instr_e ins;
  assign ins = jfp_instr_e'(instr);

  logic sel_rst, sel_unl, sel_cmd, sel_load, sel_read;
  assign sel_rst  = (ins == INS_RESET);
  assign sel_unl  = (ins == INS_UNLOCK);
  assign sel_cmd  = (ins == INS_COMMAND);
  assign sel_load = (ins == INS_LOAD);
  assign sel_read = (ins == INS_READ);

  logic        rst_q;
  logic [15:0] unl_q;
  logic [15:0] cmd_q;
  logic [7:0]  byte_q;

  // Named events, brought out for the checker.
  logic read_cap, cmd_load, load_upd, load_accept, load_reject, step, gap_ok;
  logic page_cross;

  assign read_cap    = capture_dr & sel_read & prog_mode;
  assign cmd_load    = update_dr & sel_cmd & prog_mode & cmd_q[15];
  assign load_upd    = update_dr & sel_load & prog_mode;
  assign load_accept = load_upd & gap_ok;
  assign load_reject = load_upd & ~gap_ok;
  assign step        = mem_wr_strobe | read_cap;
  assign page_cross  = step & mem_hi_sel & (&mem_addr[PAGE_BITS-1:0]);

  jfp_shift_reg #(.W(1)) u_rst_sr (
    .clk(tck), .rst_n(trst_n),
    .cap_en(capture_dr & sel_rst), .cap_val(core_reset),
    .sh_en(shift_dr & sel_rst), .din(tdi), .q(rst_q)
  );

  jfp_shift_reg #(.W(16)) u_unl_sr (
    .clk(tck), .rst_n(trst_n),
    .cap_en(1'b0), .cap_val(16'h0000),
    .sh_en(shift_dr & sel_unl), .din(tdi), .q(unl_q)
  );

  jfp_shift_reg #(.W(16)) u_cmd_sr (
    .clk(tck), .rst_n(trst_n),
    .cap_en(1'b0), .cap_val(16'h0000),
    .sh_en(shift_dr & sel_cmd), .din(tdi), .q(cmd_q)
  );

  jfp_shift_reg #(.W(8)) u_byte_sr (
    .clk(tck), .rst_n(trst_n),
    .cap_en(read_cap), .cap_val(mem_rdata),
    .sh_en(shift_dr & (sel_load | sel_read)), .din(tdi), .q(byte_q)
  );

  jfp_word_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(tck), .rst_n(trst_n),
    .load(cmd_load), .load_val(cmd_q[ADDR_W-1:0]),
    .step(step), .addr(mem_addr), .hi(mem_hi_sel)
  );

  jfp_gap_mon #(.MIN_GAP(MIN_GAP)) u_gap (
    .clk(tck), .rst_n(trst_n), .evt(load_upd), .ok(gap_ok)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      core_reset    <= 1'b0;
      prog_mode     <= 1'b0;
      mem_wr_strobe <= 1'b0;
      mem_wdata     <= '0;
      spacing_err   <= 1'b0;
    end else begin
      if (update_dr && sel_rst) core_reset <= rst_q;
      if (update_dr && sel_unl) begin
        if (key_accept(unl_q, core_reset)) prog_mode <= 1'b1;
        else if (unl_q == 16'h0000)        prog_mode <= 1'b0;
      end
      mem_wr_strobe <= load_accept;
      if (load_accept) mem_wdata <= byte_q;
      if (load_reject) spacing_err <= 1'b1;
    end
  end

  always_comb begin
    unique case (ins)
      INS_RESET:          tdo = rst_q;
      INS_UNLOCK:         tdo = unl_q[0];
      INS_COMMAND:        tdo = prog_mode & cmd_q[0];
      INS_LOAD, INS_READ: tdo = prog_mode & byte_q[0];
      default:            tdo = 1'b0;
    endcase
  end

endmodule

// File: rtl/jtag_flash_dr_chk.sv
module jtag_flash_dr_chk #(
  parameter int ADDR_W    = 15,
  parameter int PAGE_BITS = 6
) (
  input logic              tck,
  input logic              trst_n,
  input logic              prog_mode,
  input logic              core_reset,
  input logic              mem_wr_strobe,
  input logic              spacing_err,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_hi_sel,
  input logic              step,
  input logic              cmd_load,
  input logic              load_reject,
  input logic              page_cross
);

  AST_PROG_NEEDS_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(prog_mode) |-> core_reset); // R3

  AST_STROBE_SINGLE: assert property (@(posedge tck) disable iff (!trst_n)
    mem_wr_strobe |=> !mem_wr_strobe); // R8

  AST_STROBE_NEEDS_PROG: assert property (@(posedge tck) disable iff (!trst_n)
    mem_wr_strobe |-> prog_mode); // R10

  AST_ERR_STICKY: assert property (@(posedge tck) disable iff (!trst_n)
    spacing_err |=> spacing_err); // R9

  AST_REJECT_SILENT: assert property (@(posedge tck) disable iff (!trst_n)
    load_reject |=> (!mem_wr_strobe && spacing_err)); // R9

  AST_LOW_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
    (step && !mem_hi_sel && !cmd_load) |=> (mem_hi_sel && $stable(mem_addr))); // R6

  AST_HIGH_ADVANCES: assert property (@(posedge tck) disable iff (!trst_n)
    (step && mem_hi_sel && !cmd_load) |=>
      (!mem_hi_sel && mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R6

  AST_PAGE_ROLL: assert property (@(posedge tck) disable iff (!trst_n)
    (page_cross && !cmd_load) |=> (mem_addr[PAGE_BITS-1:0] == '0)); // R7

  AST_CMD_LOW: assert property (@(posedge tck) disable iff (!trst_n)
    cmd_load |=> !mem_hi_sel); // R5

endmodule

bind jtag_flash_dr jtag_flash_dr_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .tck(tck), .trst_n(trst_n), .prog_mode(prog_mode), .core_reset(core_reset),
  .mem_wr_strobe(mem_wr_strobe), .spacing_err(spacing_err), .mem_addr(mem_addr),
  .mem_hi_sel(mem_hi_sel), .step(step), .cmd_load(cmd_load),
  .load_reject(load_reject), .page_cross(page_cross)
);

// File: tb/sim_jtag_flash_dr.sv
`timescale 1ns/1ps
module sim_jtag_flash_dr;

  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic [2:0]  instr = 3'd0;
  logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic        tdo, core_reset, prog_mode, mem_hi_sel, mem_wr_strobe, spacing_err;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  always #2.5 tck = ~tck;

  // Flash array model: byte content as a function of word address and byte select.
  function automatic logic [7:0] flash_byte(input logic [14:0] a, input logic h);
    return h ? ~a[7:0] : (a[7:0] ^ 8'h3C);
  endfunction
  assign mem_rdata = flash_byte(mem_addr, mem_hi_sel);

  jtag_flash_dr u0 (
    .tck(tck), .trst_n(trst_n), .instr(instr), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .core_reset(core_reset), .prog_mode(prog_mode), .mem_addr(mem_addr),
    .mem_hi_sel(mem_hi_sel), .mem_wdata(mem_wdata), .mem_wr_strobe(mem_wr_strobe),
    .mem_rdata(mem_rdata), .spacing_err(spacing_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct packed { logic [14:0] a; logic h; logic [7:0] d; } wr_t;
  wr_t exp_q[$];

  logic [14:0] m_addr;
  logic        m_hi;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the update (+idle).
  task automatic scan(input logic [2:0] ins, input int width, input logic [15:0] din,
                      input int idle, output logic [15:0] dout);
    dout = '0;
    instr = ins;
    capture_dr = 1'b1;
    @(negedge tck);
    capture_dr = 1'b0;
    for (int i = 0; i < width; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      shift_dr = 1'b1;
      @(negedge tck);
    end
    shift_dr = 1'b0;
    tdi = 1'b0;
    update_dr = 1'b1;
    @(negedge tck);
    update_dr = 1'b0;
    repeat (idle) @(negedge tck);
  endtask

  // Driver: one load byte; pushes the expected write when it should be accepted.
  task automatic load_byte(input logic [7:0] d, input int idle, input bit accept);
    logic [15:0] dummy;
    if (accept) begin
      exp_q.push_back('{a: m_addr, h: m_hi, d: d});
      if (m_hi) m_addr = m_addr + 15'd1;
      m_hi = ~m_hi;
    end
    scan(3'd4, 8, {8'h00, d}, idle, dummy);
  endtask

  task automatic read_byte(input string req);
    logic [15:0] got;
    logic [7:0]  want;
    want = flash_byte(m_addr, m_hi);
    scan(3'd5, 8, 16'h0000, 1, got);
    chk(req, {24'h0, got[7:0]}, {24'h0, want});
    if (m_hi) m_addr = m_addr + 15'd1;
    m_hi = ~m_hi;
  endtask

  // Monitor: compares every write strobe against the scoreboard (R8, R10).
  always @(negedge tck) begin
    if (trst_n && mem_wr_strobe === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R8/R10 unexpected write actual=%h/%b/%h expected=none",
                 mem_addr, mem_hi_sel, mem_wdata);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        chk("R8 write addr", {17'h0, mem_addr}, {17'h0, e.a});
        chk("R8 write hi",   {31'h0, mem_hi_sel}, {31'h0, e.h});
        chk("R8 write data", {24'h0, mem_wdata}, {24'h0, e.d});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    @(negedge tck);

    // R1 reset state
    chk("R1 prog_mode",   {31'h0, prog_mode}, 0);
    chk("R1 core_reset",  {31'h0, core_reset}, 0);
    chk("R1 strobe",      {31'h0, mem_wr_strobe}, 0);
    chk("R1 spacing_err", {31'h0, spacing_err}, 0);
    chk("R1 mem_addr",    {17'h0, mem_addr}, 0);
    chk("R1 mem_hi_sel",  {31'h0, mem_hi_sel}, 0);

    // R3 key without core reset is refused
    scan(3'd2, 16, 16'hA370, 2, d);
    chk("R3 key without reset", {31'h0, prog_mode}, 0);

    // R2 reset register
    scan(3'd1, 1, 16'h0001, 2, d);
    chk("R2 captured old reset", {31'h0, d[0]}, 0);
    chk("R2 core_reset set", {31'h0, core_reset}, 1);

    // R3 wrong key
    scan(3'd2, 16, 16'h1234, 2, d);
    chk("R3 wrong key", {31'h0, prog_mode}, 0);

    // R10 locked: read, command and load have no effect
    scan(3'd5, 8, 16'h0000, 2, d);
    chk("R10 tdo zero when locked", {16'h0, d}, 0);
    scan(3'd3, 16, 16'h8055, 2, d);
    chk("R10 command ignored", {17'h0, mem_addr}, 0);
    scan(3'd4, 8, 16'h00FF, 2, d);
    chk("R10 load ignored hi", {31'h0, mem_hi_sel}, 0);
    chk("R10 load ignored err", {31'h0, spacing_err}, 0);

    // R3 correct key
    scan(3'd2, 16, 16'hA370, 2, d);
    chk("R3 unlock", {31'h0, prog_mode}, 1);

    // R5 command without bit 15, then with it
    scan(3'd3, 16, 16'h0123, 2, d);
    chk("R5 bit15 clear ignored", {17'h0, mem_addr}, 0);
    scan(3'd3, 16, 16'h803E, 2, d);
    chk("R5 address loaded", {17'h0, mem_addr}, 32'h3E);
    chk("R5 low byte selected", {31'h0, mem_hi_sel}, 0);

    // R6/R7 read burst across a page boundary
    m_addr = 15'h003E;
    m_hi   = 1'b0;
    for (int k = 0; k < 6; k++) begin
      read_byte("R6 read byte");
      if (k == 0) chk("R6 low byte holds address", {17'h0, mem_addr}, 32'h3E);
      if (k == 3) chk("R7 page roll", {17'h0, mem_addr}, 32'h40);
    end
    chk("R7 address after burst", {17'h0, mem_addr}, 32'h41);
    chk("R6 select after burst", {31'h0, mem_hi_sel}, 0);

    // R8 page load at exact minimum spacing
    scan(3'd3, 16, 16'h8100, 2, d);
    m_addr = 15'h0100;
    m_hi   = 1'b0;
    load_byte(8'h11, 1, 1'b1);
    load_byte(8'h12, 1, 1'b1);
    load_byte(8'h13, 1, 1'b1);
    load_byte(8'h14, 1, 1'b1);
    chk("R8 address after loads", {17'h0, mem_addr}, 32'h102);
    chk("R8 spacing ok", {31'h0, spacing_err}, 0);

    // R9 one update too early
    load_byte(8'h21, 0, 1'b1);
    load_byte(8'h22, 1, 1'b0);
    chk("R9 error flag", {31'h0, spacing_err}, 1);
    chk("R9 select unchanged", {31'h0, mem_hi_sel}, 1);
    chk("R9 address unchanged", {17'h0, mem_addr}, 32'h102);
    load_byte(8'h23, 2, 1'b1);
    chk("R9 sticky", {31'h0, spacing_err}, 1);
    chk("R9 resumes", {17'h0, mem_addr}, 32'h103);

    // R4 leave programming mode
    scan(3'd2, 16, 16'h0000, 2, d);
    chk("R4 prog cleared", {31'h0, prog_mode}, 0);
    chk("R4 reset kept", {31'h0, core_reset}, 1);
    scan(3'd5, 8, 16'h0000, 2, d);
    chk("R10 tdo zero after exit", {16'h0, d}, 0);
    chk("R10 address held after exit", {17'h0, mem_addr}, 32'h103);

    // R2 release reset
    scan(3'd1, 1, 16'h0000, 2, d);
    chk("R2 captured reset", {31'h0, d[0]}, 1);
    chk("R2 core_reset released", {31'h0, core_reset}, 0);

    repeat (3) @(negedge tck);
    chk("R8 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule